// File: doc/BRIEF.md
# Parallel Camera Capture Interface

This block takes pixels from an image sensor that drives a parallel bus: a pixel clock, a frame-valid strobe, a line-valid strobe and a data bus of up to 10 bits. It also produces a divided master clock that the sensor runs from. Each line is cut at a programmed width and each frame is checked against a programmed height. Accepted pixels are packed into 16-bit entries and stored in a receive FIFO. From there, a DMA engine or software drains them through a small register port.

Start-of-frame, end-of-line, end-of-frame and FIFO overrun each set a sticky status bit. Each of these bits has its own interrupt mask. The FIFO fill level is compared against a selectable threshold to produce a DMA request. Writing 0 to the enable bit stops capture at once and sets a done flag. All sensor inputs are sampled in the system clock domain. A pixel is taken on each rising edge of the pixel clock seen in that domain.

Top module: `cam_capture_top`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x3C (all four interrupt masks set, everything else off), STAT (address 3) reads 0x40 (FIFO empty), LEVEL (address 4) reads 0, and `irq_o`, `dma_req_o` and `cam_mclk_o` are low.
- R2: While CTRL bit 7 is set, `cam_mclk_o` toggles every DIV+1 system clocks, where DIV is register address 2 bits [7:0]. While bit 7 is clear, the output stays low.
- R3: A pixel is captured on a pixel-clock rising edge only when both CTRL bit 0 (enable) and CTRL bit 6 (pixel clock enable) are set, and frame-valid and line-valid are both active. The active level is high, or low when CTRL bit 9 (frame) or bit 8 (line) is set.
- R4: SIZE (address 1) holds width minus one in bits [10:0] and height minus one in bits [26:16]. Pixels beyond the width in a line are dropped.
- R5: With CTRL bit 10 set, each pixel becomes one entry {6'b0, data[9:0]}. With bit 10 clear, two consecutive pixels of a line form {second[7:0], first[7:0]}. An odd last pixel is flushed at line end as {8'h00, pixel[7:0]}.
- R6: STAT bit 0 (start-of-frame) is set when frame-valid becomes active. Bit 1 (end-of-line) is set when line-valid becomes inactive inside a frame. Bit 2 (end-of-frame) is set when frame-valid becomes inactive after exactly height lines. Writing 1 to a status bit clears it.
- R7: `irq_o` is high exactly when one of STAT bits [3:0] is set and the matching CTRL mask bit (bits [5:2] in the same order) is clear.
- R8: The FIFO holds DEPTH entries (default 64, i.e. 128 bytes). A pixel that arrives while the FIFO is full is dropped and sets STAT bit 3, which is sticky until written with 1.
- R9: `dma_req_o` is high when CTRL bit 1 is set and the FIFO level reaches the threshold chosen by CTRL bits [12:11]. The settings 0, 1, 2 and 3 mean 3/4, 1/2, 1/4 of DEPTH and one entry; setting 0 is 96 bytes by default.
- R10: Writing CTRL with bit 0 clear while it was set stops capture immediately and sets STAT bit 4 (disable done), which is cleared by writing 1.
- R11: LEVEL reads the FIFO fill in bytes (entries times two). A read of DATA (address 5) returns the oldest entry in bits [15:0] and removes it. STAT bit 5 shows that the FIFO is not empty and bit 6 shows that it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cam_pclk_i | input | 1 | Sensor pixel clock, sampled by clk |
| cam_fv_i | input | 1 | Frame-valid strobe |
| cam_lv_i | input | 1 | Line-valid strobe |
| cam_data_i | input | 10 | Pixel data bus |
| cam_mclk_o | output | 1 | Divided master clock to the sensor |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops FIFO on DATA) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt, OR of unmasked status |
| dma_req_o | output | 1 | FIFO threshold DMA request |

## Verification
The bench captures frames in 10-bit mode and in 8-bit mode with an odd width. This separates one-entry-per-pixel packing from pair packing with a line-end flush. A line longer than the programmed width shows that the cut is made at the width field. A frame with inverted strobes shows that the polarity bits are honoured, and a frame with pixel clock disabled shows that gating works. A frame one line short of the height sets end-of-line but not end-of-frame. A 70-pixel line fills the FIFO, so overrun and the DMA threshold can be checked on both sides of 96 bytes. A quick disable before a frame shows that nothing is stored after it.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

    localparam int DATA_W = 10;
    localparam int ENT_W  = 16;
    localparam int SZ_W   = 11;
    localparam int CNT_W  = SZ_W + 1;
    localparam int ST_W   = 5;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_SIZE = 3'd1;
    localparam logic [2:0] A_CDIV = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_LVL  = 3'd4;
    localparam logic [2:0] A_DATA = 3'd5;

    localparam int ST_SOF  = 0;
    localparam int ST_EOL  = 1;
    localparam int ST_EOF  = 2;
    localparam int ST_OVR  = 3;
    localparam int ST_DONE = 4;

    // bit 0 en, 1 dma_en, [5:2] masks (sof,eol,eof,ovr), 6 pclk_en,
    // 7 mclk_en, 8 line polarity, 9 frame polarity, 10 wide, [12:11] thr
    typedef struct packed {
        logic [1:0] thr;
        logic       wide;
        logic       fpol;
        logic       lpol;
        logic       mclk_en;
        logic       pclk_en;
        logic [3:0] mask;
        logic       dma_en;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic int thr_entries(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return (depth * 3) / 4;
            2'd1:    return depth / 2;
            2'd2:    return depth / 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/cam_mclk_gen.sv
module cam_mclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mclk_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             out;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (st_q.cnt == div_i) begin
            st_d.cnt = '0;
            st_d.out = ~st_q.out;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mclk_o = st_q.out;

endmodule

// File: rtl/cam_sync_track.sv
module cam_sync_track
    import cam_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              fv_i,
    input  logic              lv_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              fpol_i,
    input  logic              lpol_i,
    input  logic [SZ_W-1:0]   ppl_m1_i,
    input  logic [SZ_W-1:0]   lpf_m1_i,
    output logic              pix_vld_o,
    output logic [DATA_W-1:0] pix_o,
    output logic              sof_o,
    output logic              eol_o,
    output logic              eof_o
);

    typedef struct packed {
        logic              fv_p;
        logic              lv_p;
        logic [CNT_W-1:0]  pix_cnt;
        logic [CNT_W-1:0]  line_cnt;
        logic              pix_vld;
        logic [DATA_W-1:0] pix;
        logic              sof;
        logic              eol;
        logic              eof;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic             fa;
        logic             la;
        logic [CNT_W-1:0] pc;
        logic [CNT_W-1:0] lc;
        st_d         = st_q;
        st_d.pix_vld = 1'b0;
        st_d.sof     = 1'b0;
        st_d.eol     = 1'b0;
        st_d.eof     = 1'b0;
        fa = fv_i ^ fpol_i;
        la = lv_i ^ lpol_i;
        pc = st_q.pix_cnt;
        lc = st_q.line_cnt;
        if (tick_i) begin
            st_d.fv_p = fa;
            st_d.lv_p = la;
            if (fa && !st_q.fv_p) begin
                st_d.sof = 1'b1;
                pc = '0;
                lc = '0;
            end else if (fa && st_q.lv_p && !la) begin
                st_d.eol = 1'b1;
                pc = '0;
                lc = lc + 1'b1;
            end else if (!fa && st_q.fv_p && (lc == ({1'b0, lpf_m1_i} + 1'b1))) begin
                st_d.eof = 1'b1;
            end
            if (fa && la && (pc <= {1'b0, ppl_m1_i})) begin
                st_d.pix_vld = 1'b1;
                st_d.pix     = data_i;
                pc = pc + 1'b1;
            end
            st_d.pix_cnt  = pc;
            st_d.line_cnt = lc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_vld_o = st_q.pix_vld;
    assign pix_o     = st_q.pix;
    assign sof_o     = st_q.sof;
    assign eol_o     = st_q.eol;
    assign eof_o     = st_q.eof;

endmodule

// File: rtl/cam_pixel_pack.sv
module cam_pixel_pack
    import cam_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              sof_i,
    input  logic              pix_vld_i,
    input  logic [DATA_W-1:0] pix_i,
    input  logic              line_end_i,
    output logic              ent_vld_o,
    output logic [ENT_W-1:0]  ent_o
);

    typedef struct packed {
        logic             half;
        logic [7:0]       hold;
        logic             vld;
        logic [ENT_W-1:0] data;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic h;
        st_d     = st_q;
        st_d.vld = 1'b0;
        h = sof_i ? 1'b0 : st_q.half;
        if (pix_vld_i) begin
            if (wide_i) begin
                st_d.vld  = 1'b1;
                st_d.data = {{(ENT_W-DATA_W){1'b0}}, pix_i};
            end else if (!h) begin
                st_d.hold = pix_i[7:0];
                h = 1'b1;
            end else begin
                st_d.vld  = 1'b1;
                st_d.data = {pix_i[7:0], st_q.hold};
                h = 1'b0;
            end
        end else if (line_end_i && h) begin
            st_d.vld  = 1'b1;
            st_d.data = {8'h00, st_q.hold};
            h = 1'b0;
        end
        st_d.half = h;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent_vld_o = st_q.vld;
    assign ent_o     = st_q.data;

endmodule

// File: rtl/cam_rx_fifo.sv
module cam_rx_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  din_i,
    input  logic          pop_i,
    output logic [W-1:0]  dout_o,
    output logic [CW-1:0] cnt_o,
    output logic          empty_o,
    output logic          ovr_o
);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic full, push_ok, pop_ok;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign push_ok = push_i && !full;
    assign pop_ok  = pop_i && !empty_o;
    assign ovr_o   = push_i && full;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wptr = nxt(st_q.wptr);
        if (pop_ok)  st_d.rptr = nxt(st_q.rptr);
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wptr] <= din_i;
    end

    assign dout_o = mem[st_q.rptr];
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/cam_capture_top.sv
module cam_capture_top
    import cam_cap_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cam_pclk_i,
    input  logic              cam_fv_i,
    input  logic              cam_lv_i,
    input  logic [DATA_W-1:0] cam_data_i,
    output logic              cam_mclk_o,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o,
    output logic              dma_req_o
);

    typedef struct packed {
        ctrl_t           ctrl;
        logic [SZ_W-1:0] ppl;
        logic [SZ_W-1:0] lpf;
        logic [7:0]      div;
        logic [ST_W-1:0] stat;
        logic            pclk_q;
    } st_t;

    localparam ctrl_t CTRL_RST = '{mask: 4'hF, default: '0};

    st_t st_d, st_q;

    logic              tick;
    logic              pix_vld, ev_sof, ev_eol, ev_eof;
    logic [DATA_W-1:0] pix;
    logic              ent_vld;
    logic [ENT_W-1:0]  ent;
    logic              fifo_pop, fifo_empty, fifo_ovr;
    logic [ENT_W-1:0]  fifo_dout;
    logic [CW-1:0]     fifo_cnt;
    logic              unused_wdata;

    assign unused_wdata = ^{reg_wdata_i[31:27], reg_wdata_i[15:13]};

    assign tick = cam_pclk_i && !st_q.pclk_q && st_q.ctrl.en && st_q.ctrl.pclk_en;

    always_comb begin
        logic [ST_W-1:0] set_v;
        st_d        = st_q;
        st_d.pclk_q = cam_pclk_i;
        set_v       = '0;
        set_v[ST_SOF] = ev_sof;
        set_v[ST_EOL] = ev_eol;
        set_v[ST_EOF] = ev_eof;
        set_v[ST_OVR] = fifo_ovr;
        if (reg_wr_i) begin
            case (reg_addr_i)
                A_CTRL: begin
                    st_d.ctrl = ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
                    if (st_q.ctrl.en && !reg_wdata_i[0]) set_v[ST_DONE] = 1'b1;
                end
                A_SIZE: begin
                    st_d.ppl = reg_wdata_i[SZ_W-1:0];
                    st_d.lpf = reg_wdata_i[16 +: SZ_W];
                end
                A_CDIV: st_d.div = reg_wdata_i[7:0];
                A_STAT: st_d.stat = st_q.stat & ~reg_wdata_i[ST_W-1:0];
                default: ;
            endcase
        end
        st_d.stat = st_d.stat | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr_i)
            A_CTRL:  reg_rdata_o = 32'(st_q.ctrl);
            A_SIZE:  reg_rdata_o = {5'b0, st_q.lpf, 5'b0, st_q.ppl};
            A_CDIV:  reg_rdata_o = {24'b0, st_q.div};
            A_STAT:  reg_rdata_o = {25'b0, fifo_empty, !fifo_empty, st_q.stat};
            A_LVL:   reg_rdata_o = 32'({fifo_cnt, 1'b0});
            A_DATA:  reg_rdata_o = {{(32-ENT_W){1'b0}}, fifo_dout};
            default: reg_rdata_o = '0;
        endcase
    end

    assign fifo_pop  = reg_rd_i && (reg_addr_i == A_DATA);
    assign irq_o     = |(st_q.stat[ST_OVR:ST_SOF] & ~st_q.ctrl.mask);
    assign dma_req_o = st_q.ctrl.dma_en &&
                       (fifo_cnt >= CW'(thr_entries(st_q.ctrl.thr, DEPTH)));

    cam_mclk_gen #(.DIV_W(8)) u_mclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (st_q.ctrl.mclk_en),
        .div_i  (st_q.div),
        .mclk_o (cam_mclk_o)
    );

    cam_sync_track u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .fv_i      (cam_fv_i),
        .lv_i      (cam_lv_i),
        .data_i    (cam_data_i),
        .fpol_i    (st_q.ctrl.fpol),
        .lpol_i    (st_q.ctrl.lpol),
        .ppl_m1_i  (st_q.ppl),
        .lpf_m1_i  (st_q.lpf),
        .pix_vld_o (pix_vld),
        .pix_o     (pix),
        .sof_o     (ev_sof),
        .eol_o     (ev_eol),
        .eof_o     (ev_eof)
    );

    cam_pixel_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide_i     (st_q.ctrl.wide),
        .sof_i      (ev_sof),
        .pix_vld_i  (pix_vld),
        .pix_i      (pix),
        .line_end_i (ev_eol),
        .ent_vld_o  (ent_vld),
        .ent_o      (ent)
    );

    cam_rx_fifo #(.DEPTH(DEPTH), .W(ENT_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (ent_vld),
        .din_i   (ent),
        .pop_i   (fifo_pop),
        .dout_o  (fifo_dout),
        .cnt_o   (fifo_cnt),
        .empty_o (fifo_empty),
        .ovr_o   (fifo_ovr)
    );

    logic          chk_mclk_en, chk_en, chk_dma_en;
    logic [3:0]    chk_mask;
    logic [ST_W-1:0] chk_stat;
    assign chk_mclk_en = st_q.ctrl.mclk_en;
    assign chk_en      = st_q.ctrl.en;
    assign chk_dma_en  = st_q.ctrl.dma_en;
    assign chk_mask    = st_q.ctrl.mask;
    assign chk_stat    = st_q.stat;

endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mclk_en,
    input logic          en,
    input logic          dma_en,
    input logic [3:0]    mask,
    input logic [4:0]    stat,
    input logic [CW-1:0] fifo_cnt,
    input logic          reg_wr_i,
    input logic [2:0]    reg_addr_i,
    input logic [31:0]   reg_wdata_i,
    input logic          cam_mclk_o,
    input logic          irq_o,
    input logic          dma_req_o
);

    // R2
    mclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_en |=> !cam_mclk_o);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[3] && !(reg_wr_i && reg_addr_i == 3'd3 && reg_wdata_i[3])) |=> stat[3]);

    // R8
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 4'hF) |-> !irq_o);

    // R10
    qdis_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 3'd0 && !reg_wdata_i[0] && en) |=> stat[4]);

    // R9
    dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req_o);

endmodule

bind cam_capture_top cam_capture_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mclk_en     (chk_mclk_en),
    .en          (chk_en),
    .dma_en      (chk_dma_en),
    .mask        (chk_mask),
    .stat        (chk_stat),
    .fifo_cnt    (fifo_cnt),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .cam_mclk_o  (cam_mclk_o),
    .irq_o       (irq_o),
    .dma_req_o   (dma_req_o)
);

// File: tb/cam_capture_top_bench.sv
`timescale 1ns/1ps
module cam_capture_top_bench;

    localparam int DEPTH = 64;
    localparam logic [2:0] A_CTRL = 3'd0, A_SIZE = 3'd1, A_CDIV = 3'd2,
                           A_STAT = 3'd3, A_LVL = 3'd4, A_DATA = 3'd5;
    localparam logic [31:0] C_EN = 32'h1, C_DMA = 32'h2, C_PCLK = 32'h40,
                            C_MCLK = 32'h80, C_LPOL = 32'h100, C_FPOL = 32'h200,
                            C_WIDE = 32'h400, C_MASKS = 32'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cam_pclk = 1'b0, cam_fv = 1'b0, cam_lv = 1'b0;
    logic [9:0]  cam_data = '0;
    logic        cam_mclk;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, dma_req;

    int vectors = 0;
    int errors  = 0;
    int model_level = 0;
    logic [15:0] exp_q[$];
    logic [31:0] rv;

    always #4 clk = ~clk;

    cam_capture_top #(.DEPTH(DEPTH)) u_cam_capture_top (
        .clk (clk), .rst_n (rst_n),
        .cam_pclk_i (cam_pclk), .cam_fv_i (cam_fv), .cam_lv_i (cam_lv),
        .cam_data_i (cam_data), .cam_mclk_o (cam_mclk),
        .reg_wr_i (reg_wr), .reg_rd_i (reg_rd), .reg_addr_i (reg_addr),
        .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata),
        .irq_o (irq), .dma_req_o (dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pix(input logic fv, input logic lv, input logic [9:0] d);
        @(negedge clk);
        cam_pclk = 1'b0; cam_fv = fv; cam_lv = lv; cam_data = d;
        @(negedge clk);
        cam_pclk = 1'b1;
    endtask

    task automatic push_exp(input logic [15:0] e);
        if (model_level < DEPTH) begin
            exp_q.push_back(e);
            model_level++;
        end
    endtask

    // Driver: plays one frame and predicts the entries it must produce.
    task automatic frame(input int npix, input int nlines, input int base,
                         input logic pl, input logic pf, input logic wide,
                         input int width, input logic cap);
        logic fa, fi, la, li;
        fa = ~pf; fi = pf; la = ~pl; li = pl;
        pix(fi, li, '0);
        pix(fa, li, '0);
        for (int l = 0; l < nlines; l++) begin
            logic       half;
            logic [7:0] hold;
            half = 1'b0; hold = '0;
            for (int p = 0; p < npix; p++) begin
                logic [9:0] v;
                v = 10'(base + l * 16 + p);
                pix(fa, la, v);
                if (cap && p < width) begin
                    if (wide) push_exp({6'b0, v});
                    else if (!half) begin hold = v[7:0]; half = 1'b1; end
                    else begin push_exp({v[7:0], hold}); half = 1'b0; end
                end
            end
            pix(fa, li, '0);
            if (half) push_exp({8'h00, hold});
        end
        pix(fi, li, '0);
        pix(fi, li, '0);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pops the design's entries and compares them with the queue.
    task automatic drain(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [31:0] got;
            logic [15:0] e;
            rd(A_DATA, got);
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hDEAD;
            model_level--;
            chk(tag, got, {16'b0, e});
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        int hi, lo;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, rv); chk("R1 ctrl", rv, 32'h3C);
        rd(A_STAT, rv); chk("R1 stat", rv, 32'h40);
        rd(A_LVL, rv);  chk("R1 level", rv, 0);
        chk("R1 outputs", {29'b0, irq, dma_req, cam_mclk}, 0);

        // R2 master clock divide by 3 per half period
        wr(A_CDIV, 32'd2);
        wr(A_CTRL, C_MASKS | C_MCLK);
        while (cam_mclk !== 1'b1) @(negedge clk);
        hi = 0; while (cam_mclk === 1'b1) begin hi++; @(negedge clk); end
        lo = 0; while (cam_mclk === 1'b0) begin lo++; @(negedge clk); end
        chk("R2 high time", hi, 3);
        chk("R2 low time", lo, 3);
        wr(A_CTRL, C_MASKS);
        repeat (3) @(negedge clk);
        chk("R2 idle low", {31'b0, cam_mclk}, 0);

        // R5 R6 R11 10-bit frame 4x2
        wr(A_SIZE, {5'b0, 11'd1, 5'b0, 11'd3});
        wr(A_CTRL, C_MASKS | C_EN | C_PCLK | C_WIDE);
        frame(4, 2, 10'h100, 1'b0, 1'b0, 1'b1, 4, 1'b1);
        rd(A_LVL, rv);  chk("R11 level bytes", rv, 16);
        rd(A_STAT, rv); chk("R6 sof eol eof", rv, 32'h27);
        chk("R7 masked irq", {31'b0, irq}, 0);
        drain(8, "R5 wide entries");
        rd(A_STAT, rv); chk("R11 empty flag", rv, 32'h47);

        // R7 unmask end-of-frame, then clear it by writing 1
        wr(A_CTRL, (C_MASKS & ~32'h10) | C_EN | C_PCLK | C_WIDE);
        @(negedge clk); chk("R7 irq unmasked", {31'b0, irq}, 1);
        wr(A_STAT, 32'h4);
        chk("R7 irq after clear", {31'b0, irq}, 0);
        rd(A_STAT, rv); chk("R6 w1c eof", rv, 32'h43);
        wr(A_STAT, 32'h1F);

        // R5 8-bit mode with odd width 3
        wr(A_SIZE, {5'b0, 11'd0, 5'b0, 11'd2});
        wr(A_CTRL, C_MASKS | C_EN | C_PCLK);
        frame(3, 1, 10'h3A5, 1'b0, 1'b0, 1'b0, 3, 1'b1);
        rd(A_LVL, rv); chk("R5 packed level", rv, 4);
        drain(2, "R5 packed entries");
        wr(A_STAT, 32'h1F);

        // R4 six pixels into width 4
        wr(A_SIZE, {5'b0, 11'd0, 5'b0, 11'd3});
        wr(A_CTRL, C_MASKS | C_EN | C_PCLK | C_WIDE);
        frame(6, 1, 10'h040, 1'b0, 1'b0, 1'b1, 4, 1'b1);
        rd(A_LVL, rv); chk("R4 width cut", rv, 8);
        drain(4, "R4 entries");
        wr(A_STAT, 32'h1F);

        // R3 active-low strobes
        wr(A_SIZE, {5'b0, 11'd0, 5'b0, 11'd1});
        wr(A_CTRL, C_MASKS | C_EN | C_PCLK | C_WIDE | C_LPOL | C_FPOL);
        frame(2, 1, 10'h2F0, 1'b1, 1'b1, 1'b1, 2, 1'b1);
        rd(A_LVL, rv); chk("R3 inverted polarity", rv, 4);
        drain(2, "R3 entries");
        rd(A_STAT, rv); chk("R3 events inverted", rv, 32'h47);
        wr(A_STAT, 32'h1F);

        // R3 pixel clock disabled
        wr(A_CTRL, C_MASKS | C_EN | C_WIDE);
        frame(2, 1, 10'h010, 1'b0, 1'b0, 1'b1, 2, 1'b0);
        rd(A_STAT, rv); chk("R3 pclk gated", rv, 32'h40);

        // R6 frame one line short of height 2
        wr(A_SIZE, {5'b0, 11'd1, 5'b0, 11'd1});
        wr(A_CTRL, C_MASKS | C_EN | C_PCLK | C_WIDE);
        frame(2, 1, 10'h020, 1'b0, 1'b0, 1'b1, 2, 1'b1);
        rd(A_STAT, rv); chk("R6 no eof when short", rv, 32'h23);
        drain(2, "R6 entries");
        wr(A_STAT, 32'h1F);

        // R8 R9 overrun and DMA threshold
        wr(A_SIZE, {5'b0, 11'd0, 5'b0, 11'd69});
        wr(A_CTRL, C_MASKS | C_EN | C_PCLK | C_WIDE | C_DMA);
        chk("R9 no request empty", {31'b0, dma_req}, 0);
        frame(70, 1, 10'h000, 1'b0, 1'b0, 1'b1, 70, 1'b1);
        rd(A_LVL, rv); chk("R8 full level", rv, 128);
        rd(A_STAT, rv); chk("R8 overrun set", rv & 32'h8, 32'h8);
        chk("R9 request full", {31'b0, dma_req}, 1);
        drain(16, "R8 head entries");
        chk("R9 request at 96", {31'b0, dma_req}, 1);
        drain(1, "R8 entry");
        rd(A_LVL, rv); chk("R11 level 94", rv, 94);
        chk("R9 request below 96", {31'b0, dma_req}, 0);
        drain(47, "R8 tail entries");
        rd(A_STAT, rv); chk("R8 overrun sticky", rv & 32'h8, 32'h8);
        wr(A_STAT, 32'h8);
        rd(A_STAT, rv); chk("R8 overrun cleared", rv & 32'h8, 32'h0);
        wr(A_STAT, 32'h1F);

        // R10 quick disable
        wr(A_SIZE, {5'b0, 11'd0, 5'b0, 11'd1});
        wr(A_CTRL, C_MASKS | C_EN | C_PCLK | C_WIDE);
        wr(A_CTRL, C_MASKS | C_PCLK | C_WIDE);
        rd(A_STAT, rv); chk("R10 done set", rv, 32'h50);
        frame(2, 1, 10'h111, 1'b0, 1'b0, 1'b1, 2, 1'b0);
        rd(A_LVL, rv); chk("R10 nothing captured", rv, 0);
        wr(A_STAT, 32'h10);
        rd(A_STAT, rv); chk("R10 done cleared", rv, 32'h40);

        chk("R11 queue drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule